// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master of a single-wire open-drain bus. A host reaches it through a small byte-wide register bank. A write to the command register starts a bus reset with presence detection. A write to the data register sends a byte as eight timed bit slots, least significant bit first. The line is sampled in every slot, so writing 0xFF performs a byte read: the slave pulls the released line low to return zeros, and the sampled byte lands in the receive buffer.

Both directions are double buffered. The host can queue a second byte while the first is still shifting. A received byte can wait in the shift register while the receive buffer is still full. Status flags report the state of each buffer and each shift register. Enabled flags are ORed onto an interrupt output whose active level is programmable. All slot and reset durations count ticks of a prescaled time base. The prescaler ratio comes from the divisor register, and the default tick lengths assume a tick of about one microsecond.

The bit engine is a state machine. Its states are:
- IDLE
- RST_LOW: the line is driven low.
- RST_WAIT: the line is released and the engine waits for a slave to respond.
- RST_WIN: the presence window, in which the line is sampled.
- RST_TAIL: recovery after the presence window.
- BIT_LOW: the opening low pulse of a slot.
- BIT_SAMP: ends with the sample.
- BIT_REST: the rest of the slot.
- BIT_REC: released recovery.

Its transitions are:
- start_rst takes IDLE to RST_LOW.
- start_byte takes IDLE to BIT_LOW.
- The reset states follow each other in order, and RST_TAIL returns to IDLE.
- The slot states follow each other in order. BIT_REC goes back to BIT_LOW for the next bit, or to IDLE after the eighth bit.

Each state ends when its tick count runs out.

Top module: `ow_master`

## Requirements
- R1: After reset these registers read as follows:
  - interrupt status (offset 2) reads 0x04, with only the transmit-buffer-empty flag set;
  - command (offset 0) reads 0x08, with the line high;
  - interrupt enable (offset 3) reads 0x00;
  - divisor (offset 4) reads 0x00;
  - data (offset 1) reads 0x00.
  
  The irq output is 1, because the output is active-low with no source enabled, and dq_drive_low is 0.
- R2: Writing the command register with bit 0 set while the engine is idle starts a reset. The line is driven low for T_RST_LOW ticks, then released for T_PD_WAIT ticks, then sampled for T_PD_WIN ticks, then left to recover for T_RST_TAIL ticks. Command bit 0 reads 1 while the reset is running. Status bit 0 (presence done) is set at the end of the sampling window.
- R3: Status bit 1 (presence result) is set to 1 if the line stayed high for the whole sampling window. It is set to 0 if a slave pulled the line low in that window.
- R4: A byte written to the data register (offset 1) is sent least significant bit first. Each bit is one slot, followed by T_REC ticks with the line released. A 1 holds the line low for T_LOW1 ticks. A 0 holds it low for T_SLOT ticks.
- R5: In each slot the line is sampled T_SAMP ticks after the slot starts. When the byte ends, the sampled byte goes to the receive buffer, which the data register returns, and status bit 4 (receive buffer full) is set. Writing 0xFF therefore reads a byte from the slave.
- R6: The tick runs at the clock rate divided by (divisor + 1), where the divisor is held in bits 4:0 of offset 4. Every slot and reset duration scales by that ratio.
- R7: Status bit 2 (transmit buffer empty) clears on a data write. It sets again when the byte moves into the shifter, so a second byte can be queued behind one in flight. Status bit 3 (shift register empty) is set when a byte finishes. It is cleared when a new byte is loaded.
- R8: A byte that finishes while the receive buffer is still full stays in the shift register, and status bit 5 is set. No new byte starts while bit 5 is set. The first data read returns the older byte and moves the held byte up. The second data read returns the held byte and clears bit 4.
- R9: Reading the status register clears the presence-done and shift-register-empty flags. The presence result is kept until the next reset.
- R10: irq is the OR of the status flags that are enabled in the enable register (offset 3), taken through the following enable bits:
  - bit 0 enables presence done;
  - bit 2 enables transmit buffer empty;
  - bit 3 enables shift register empty;
  - bit 4 enables receive buffer full;
  - bit 5 enables receive shift register full.
  
  The output is active-high when enable bit 1 is set and active-low when it is clear.
- R11: Command bit 2 drives the line low only while enable bit 6 is set. Command bit 3 reads the line level as captured in the previous cycle.
- R12: A reset command written while a byte is being sent is ignored, and no presence-done flag results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; applies the clear-on-read effects |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt, polarity set by enable bit 1 |
| dq_drive_low | output | 1 | Pulls the open-drain line low when 1 |
| dq_in | input | 1 | Line level |

## Verification
The bench uses very short timings so that whole bytes take tens of clocks:
- reset low 12 ticks, presence wait 3, window 5, tail 4;
- slot low 2 ticks, sample at tick 4, slot length 8, recovery 1.

With these values, a sweep through all 256 byte values in both directions is affordable at divisor 0. In the write sweep, a bus model decodes each low pulse by its exact length. In the read sweep, the slave model returns each byte. A further set of bytes runs at divisor 2 to show that every duration scales with the divisor. The same short timings bring the two-deep buffer stalls, the presence outcomes and the interrupt polarity cases within a few hundred cycles.

// File: rtl/ow_pkg.sv
package ow_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_LOW,
        S_RST_WAIT,
        S_RST_WIN,
        S_RST_TAIL,
        S_BIT_LOW,
        S_BIT_SAMP,
        S_BIT_REST,
        S_BIT_REC
    } ow_state_e;
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Counter rests at zero while idle so slot phase is fixed from the start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt >= div) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt >= div);
endmodule

// File: rtl/ow_line_fsm.sv
module ow_line_fsm
    import ow_pkg::*;
#(
    parameter int T_RST_LOW  = 480,
    parameter int T_PD_WAIT  = 60,
    parameter int T_PD_WIN   = 240,
    parameter int T_RST_TAIL = 325,
    parameter int T_LOW1     = 6,
    parameter int T_SAMP     = 15,
    parameter int T_SLOT     = 60,
    parameter int T_REC      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              dq_s,
    input  logic              start_rst,
    input  logic              start_byte,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              busy,
    output logic              in_reset,
    output logic              line_low,
    output logic              pd_done,
    output logic              pd_absent,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int M1   = (T_RST_LOW > T_RST_TAIL) ? T_RST_LOW : T_RST_TAIL;
    localparam int M2   = (T_PD_WIN > T_SLOT) ? T_PD_WIN : T_SLOT;
    localparam int MAXT = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXT + 1);
    localparam int IW   = $clog2(BYTE_W);

    ow_state_e         state, nxt;
    logic [CW-1:0]     cnt, lim;
    logic              last;
    logic [IW-1:0]     bit_idx;
    logic [BYTE_W-1:0] tx_sh, rx_sh;
    logic              seen;

    always_comb begin
        unique case (state)
            S_RST_LOW:  lim = CW'(T_RST_LOW);
            S_RST_WAIT: lim = CW'(T_PD_WAIT);
            S_RST_WIN:  lim = CW'(T_PD_WIN);
            S_RST_TAIL: lim = CW'(T_RST_TAIL);
            S_BIT_LOW:  lim = CW'(T_LOW1);
            S_BIT_SAMP: lim = CW'(T_SAMP - T_LOW1);
            S_BIT_REST: lim = CW'(T_SLOT - T_SAMP);
            S_BIT_REC:  lim = CW'(T_REC);
            default:    lim = CW'(1);
        endcase
    end

    assign last = tick && (cnt == lim - 1'b1);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start_rst) nxt = S_RST_LOW;
                        else if (start_byte) nxt = S_BIT_LOW;
            S_RST_LOW:  if (last) nxt = S_RST_WAIT;
            S_RST_WAIT: if (last) nxt = S_RST_WIN;
            S_RST_WIN:  if (last) nxt = S_RST_TAIL;
            S_RST_TAIL: if (last) nxt = S_IDLE;
            S_BIT_LOW:  if (last) nxt = S_BIT_SAMP;
            S_BIT_SAMP: if (last) nxt = S_BIT_REST;
            S_BIT_REST: if (last) nxt = S_BIT_REC;
            S_BIT_REC:  if (last) nxt = (bit_idx == IW'(BYTE_W - 1)) ? S_IDLE : S_BIT_LOW;
            default:    nxt = S_IDLE;
        endcase
    end

    // State register and tick counter within the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state != nxt) cnt <= '0;
            else if (tick)    cnt <= cnt + 1'b1;
        end
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            seen    <= 1'b0;
        end else begin
            if (state == S_IDLE && start_rst) seen <= 1'b0;
            else if (state == S_IDLE && start_byte) begin
                tx_sh   <= byte_in;
                bit_idx <= '0;
            end
            if (state == S_RST_WIN && !dq_s) seen <= 1'b1;
            if (state == S_BIT_SAMP && last) rx_sh <= {dq_s, rx_sh[BYTE_W-1:1]};
            if (state == S_BIT_REC && last) begin
                tx_sh   <= tx_sh >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != S_IDLE);
        in_reset  = (state == S_RST_LOW) || (state == S_RST_WAIT) ||
                    (state == S_RST_WIN) || (state == S_RST_TAIL);
        unique case (state)
            S_RST_LOW, S_BIT_LOW:   line_low = 1'b1;
            S_BIT_SAMP, S_BIT_REST: line_low = !tx_sh[0];
            default:                line_low = 1'b0;
        endcase
        pd_done   = (state == S_RST_WIN) && last;
        pd_absent = !seen && dq_s;
        byte_done = (state == S_BIT_REC) && last && (bit_idx == IW'(BYTE_W - 1));
        byte_out  = rx_sh;
    end
endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter int T_RST_LOW  = 480,
    parameter int T_PD_WAIT  = 60,
    parameter int T_PD_WIN   = 240,
    parameter int T_RST_TAIL = 325,
    parameter int T_LOW1     = 6,
    parameter int T_SAMP     = 15,
    parameter int T_SLOT     = 60,
    parameter int T_REC      = 2,
    parameter int DIV_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    output logic              dq_drive_low,
    input  logic              dq_in
);
    logic              tick, busy, in_reset, line_low, pd_done, pd_absent, byte_done;
    logic [BYTE_W-1:0] byte_out;
    logic              dq_s, cmd_search, cmd_force;
    logic [DIV_W-1:0]  clkdiv;
    logic [6:0]        inten;
    logic [BYTE_W-1:0] tx_buf, rx_buf;
    logic              tbe, tsre, rbf, rsrf, pd, pdr;
    logic              wr_cmd, wr_data, rd_data, rd_stat, start_rst, start_byte, irq_act;

    assign wr_cmd     = reg_wr && (reg_addr == A_CMD);
    assign wr_data    = reg_wr && (reg_addr == A_DATA);
    assign rd_data    = reg_rd && (reg_addr == A_DATA);
    assign rd_stat    = reg_rd && (reg_addr == A_STAT);
    assign start_rst  = wr_cmd && reg_wdata[0] && !busy;
    assign start_byte = !busy && !tbe && !rsrf && !start_rst;

    ow_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(clkdiv), .tick(tick)
    );

    ow_line_fsm #(
        .T_RST_LOW(T_RST_LOW), .T_PD_WAIT(T_PD_WAIT), .T_PD_WIN(T_PD_WIN),
        .T_RST_TAIL(T_RST_TAIL), .T_LOW1(T_LOW1), .T_SAMP(T_SAMP),
        .T_SLOT(T_SLOT), .T_REC(T_REC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dq_s(dq_s),
        .start_rst(start_rst), .start_byte(start_byte), .byte_in(tx_buf),
        .busy(busy), .in_reset(in_reset), .line_low(line_low),
        .pd_done(pd_done), .pd_absent(pd_absent),
        .byte_done(byte_done), .byte_out(byte_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_s <= 1'b1;  cmd_search <= 1'b0;  cmd_force <= 1'b0;
            clkdiv <= '0;  inten <= '0;  tx_buf <= '0;  rx_buf <= '0;
            tbe <= 1'b1;  tsre <= 1'b0;  rbf <= 1'b0;  rsrf <= 1'b0;
            pd <= 1'b0;  pdr <= 1'b0;
        end else begin
            dq_s <= dq_in;
            if (wr_cmd) begin
                cmd_search <= reg_wdata[1];
                cmd_force  <= reg_wdata[2];
            end
            if (reg_wr && reg_addr == A_EN)  inten  <= reg_wdata[6:0];
            if (reg_wr && reg_addr == A_DIV) clkdiv <= reg_wdata[DIV_W-1:0];
            // transmit side: a data write wins over a same-cycle load
            if (start_byte) begin
                tbe  <= 1'b1;
                tsre <= 1'b0;
            end
            if (wr_data) begin
                tx_buf <= reg_wdata;
                tbe    <= 1'b0;
            end
            if (rd_stat) begin
                pd   <= 1'b0;
                tsre <= 1'b0;
            end
            if (byte_done) tsre <= 1'b1;
            if (pd_done) begin
                pd  <= 1'b1;
                pdr <= pd_absent;
            end
            // receive side
            if (byte_done) begin
                if (!rbf || rd_data) begin
                    rx_buf <= byte_out;
                    rbf    <= 1'b1;
                end else begin
                    rsrf <= 1'b1;
                end
            end else if (rd_data) begin
                if (rsrf) begin
                    rx_buf <= byte_out;
                    rsrf   <= 1'b0;
                end else begin
                    rbf <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_CMD:   reg_rdata = {4'b0, dq_s, cmd_force, cmd_search, in_reset};
            A_DATA:  reg_rdata = rx_buf;
            A_STAT:  reg_rdata = {2'b0, rsrf, rbf, tsre, tbe, pdr, pd};
            A_EN:    reg_rdata = {1'b0, inten};
            A_DIV:   reg_rdata = BYTE_W'(clkdiv);
            default: reg_rdata = '0;
        endcase
    end

    assign irq_act      = (pd & inten[0]) | (tbe & inten[2]) | (tsre & inten[3]) |
                          (rbf & inten[4]) | (rsrf & inten[5]);
    assign irq          = inten[1] ? irq_act : !irq_act;
    assign dq_drive_low = line_low | (cmd_force & inten[6]);
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk #(
    parameter int DIV_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [DIV_W-1:0] clkdiv,
    input logic             tbe,
    input logic             busy,
    input logic             pd,
    input logic             rbf,
    input logic             rsrf,
    input logic             rd_data,
    input logic             byte_done
);
    AST_TBE_SET_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tbe) |-> $rose(busy)); // R7

    AST_PD_IN_RESET_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd) |-> busy); // R2

    AST_RSRF_NEEDS_RBF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsrf) |-> rbf); // R8

    AST_DATA_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rbf && !rsrf && !byte_done) |=> !rbf); // R8

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clkdiv != '0) |=> (!tick || clkdiv == '0)); // R6
endmodule

bind ow_master ow_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clkdiv(clkdiv), .tbe(tbe),
    .busy(busy), .pd(pd), .rbf(rbf), .rsrf(rsrf), .rd_data(rd_data),
    .byte_done(byte_done)
);

// File: tb/tb_ow_master.sv
module tb_ow_master;
    localparam int P_RST_LOW = 12, P_PD_WAIT = 3, P_PD_WIN = 5, P_RST_TAIL = 4;
    localparam int P_LOW1 = 2, P_SAMP = 4, P_SLOT = 8, P_REC = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, dq_drive_low, dq_in;
    logic       slave_low = 1'b0;

    always #2 clk = !clk;
    assign dq_in = !(dq_drive_low || slave_low);

    ow_master #(
        .T_RST_LOW(P_RST_LOW), .T_PD_WAIT(P_PD_WAIT), .T_PD_WIN(P_PD_WIN),
        .T_RST_TAIL(P_RST_TAIL), .T_LOW1(P_LOW1), .T_SAMP(P_SAMP),
        .T_SLOT(P_SLOT), .T_REC(P_REC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .dq_drive_low(dq_drive_low), .dq_in(dq_in)
    );

    int checks = 0, errors = 0;
    int bdiv = 0;
    bit slave_here = 1'b1, slave_rd_en = 1'b0;
    logic [7:0] slave_byte = '0, cap = '0;
    int sidx = 0, run_bad = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bus slave model: decodes master pulses by length, answers presence and reads
    initial begin
        int low_run = 0, hold = 0, pdel = 0, plen = 0;
        bit prev_m = 1'b0, m, b;
        forever begin
            @(negedge clk);
            m = dq_drive_low;
            if (m) low_run++;
            if (m && !prev_m && slave_rd_en) begin
                if (!slave_byte[sidx]) hold = 6 * (bdiv + 1);
                sidx = (sidx + 1) % 8;
            end
            if (!m && prev_m) begin
                if (low_run >= 10 * (bdiv + 1)) begin
                    if (slave_here) begin
                        pdel = bdiv + 1;
                        plen = 5 * (bdiv + 1);
                    end
                end else begin
                    b = (low_run < 5 * (bdiv + 1));
                    cap = {b, cap[7:1]};
                    if (low_run != (b ? P_LOW1 : P_SLOT) * (bdiv + 1)) run_bad++;
                end
                low_run = 0;
            end
            prev_m = m;
            slave_low = (hold > 0) || (pdel == 0 && plen > 0);
            if (hold > 0) hold--;
            if (pdel > 0) pdel--;
            else if (plen > 0) plen--;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        waitc(3);
        rst_n = 1'b1;
        waitc(2);

        // reset values
        rd(3'd2, v); chk("R1 status", v, 8'h04);
        rd(3'd0, v); chk("R1 cmd", v, 8'h08);
        rd(3'd3, v); chk("R1 enable", v, 8'h00);
        rd(3'd4, v); chk("R1 divisor", v, 8'h00);
        rd(3'd1, v); chk("R1 data", v, 8'h00);
        chk("R1 irq idle", irq, 1);
        chk("R1 line", dq_drive_low, 0);

        // reset with slave present, presence interrupt active-high
        wr(3'd3, 8'h03);
        chk("R10 irq no source active-high", irq, 0);
        slave_here = 1'b1;
        wr(3'd0, 8'h01);
        rd(3'd0, v); chk("R2 cmd busy during reset", v, 8'h01);
        waitc(30);
        chk("R10 irq on presence", irq, 1);
        rd(3'd2, v); chk("R3 present result", v, 8'h05);
        chk("R9 irq after status read", irq, 0);
        rd(3'd2, v); chk("R9 presence flag cleared", v, 8'h04);
        rd(3'd0, v); chk("R2 cmd idle after reset", v, 8'h08);

        // reset without slave
        slave_here = 1'b0;
        wr(3'd0, 8'h01);
        waitc(30);
        rd(3'd2, v); chk("R3 absent result", v, 8'h07);
        rd(3'd2, v); chk("R9 result persists", v, 8'h06);
        wr(3'd3, 8'h00);

        // exhaustive write sweep at divisor 0
        run_bad = 0;
        for (int i = 0; i < 256; i++) begin
            cap = '0;
            wr(3'd1, 8'(i));
            waitc(80);
            rd(3'd1, v);
            chk("R4 bus bits", cap, i);
            chk("R5 sampled own byte", v, i);
        end
        chk("R4 pulse lengths div0", run_bad, 0);

        // exhaustive read sweep
        slave_rd_en = 1'b1;
        for (int i = 0; i < 256; i++) begin
            slave_byte = 8'(i); sidx = 0;
            wr(3'd1, 8'hFF);
            waitc(80);
            rd(3'd1, v);
            chk("R5 read byte", v, i);
        end
        slave_rd_en = 1'b0;

        // double buffering
        rd(3'd2, v);
        wr(3'd1, 8'hA5);
        wr(3'd1, 8'h3C);
        rd(3'd2, v); chk("R7 second byte queued", v, 8'h02);
        waitc(170);
        rd(3'd2, v); chk("R8 both buffers full", v, 8'h3E);
        wr(3'd1, 8'h0F);
        waitc(100);
        rd(3'd2, v); chk("R8 third byte stalled", v, 8'h32);
        rd(3'd1, v); chk("R8 first byte", v, 8'hA5);
        rd(3'd1, v); chk("R8 held byte", v, 8'h3C);
        waitc(85);
        rd(3'd1, v); chk("R8 third byte", v, 8'h0F);
        rd(3'd2, v); chk("R7 shifter empty flag", v, 8'h0E);

        // interrupt polarity
        wr(3'd3, 8'h12);
        chk("R10 irq high idle", irq, 0);
        wr(3'd1, 8'h55);
        waitc(85);
        chk("R10 irq rbf active-high", irq, 1);
        rd(3'd1, v);
        chk("R10 irq cleared by data read", irq, 0);
        wr(3'd3, 8'h10);
        chk("R10 irq low idle", irq, 1);
        wr(3'd1, 8'h66);
        waitc(85);
        chk("R10 irq rbf active-low", irq, 0);
        rd(3'd1, v);
        wr(3'd3, 8'h0A);
        chk("R10 irq tsre", irq, 1);
        rd(3'd2, v);
        chk("R9 tsre cleared by status read", irq, 0);

        // reset command ignored while a byte is in flight
        wr(3'd3, 8'h00);
        rd(3'd2, v);
        wr(3'd1, 8'h00);
        waitc(10);
        wr(3'd0, 8'h01);
        waitc(120);
        rd(3'd2, v); chk("R12 no presence after busy reset", v, 8'h1E);
        rd(3'd1, v);

        // divisor 2
        wr(3'd4, 8'h02);
        bdiv = 2;
        rd(3'd4, v); chk("R6 divisor readback", v, 8'h02);
        run_bad = 0;
        for (int k = 0; k < 8; k++) begin
            cap = '0;
            wr(3'd1, 8'(k * 37 + 1));
            waitc(240);
            rd(3'd1, v);
            chk("R6 bits at div2", cap, (k * 37 + 1) & 255);
            chk("R6 sample at div2", v, (k * 37 + 1) & 255);
        end
        chk("R6 pulse lengths div2", run_bad, 0);

        // direct line drive
        wr(3'd0, 8'h04);
        chk("R11 force gated off", dq_drive_low, 0);
        rd(3'd0, v); chk("R11 cmd force high line", v, 8'h0C);
        wr(3'd3, 8'h40);
        chk("R11 force drives line", dq_drive_low, 1);
        rd(3'd0, v); chk("R11 cmd reads low line", v, 8'h04);
        wr(3'd0, 8'h00);
        chk("R11 force released", dq_drive_low, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule